// File: doc/BRIEF.md
# Framebuffer Control Register Interrupt Unit

This block is the register window of a simple framebuffer controller. It is byte-addressed and 32 bytes wide. The upper sixteen bytes hold three things: a control byte whose top bit enables the frame interrupt, a status byte, and fourteen general bytes that software uses for cursor and video-timing values. Every read of the status byte returns a sticky pending flag in its top bit. Fixed identification bits are merged into the other positions: monitor-resolution code 0x60 and colour-display flag 0x01. The lower sixteen bytes belong to palette logic outside this block. Here they read as zero and writes to them have no effect.

The display scanout delivers a one-cycle end-of-frame pulse. When interrupts are enabled, that pulse sets the pending flag, and the interrupt line follows the flag as a registered level. Software acknowledges by writing any value to the status byte. A bus access moves one to four bytes. Byte k of the access uses data lane k (bits 8k+7..8k) and targets window offset addr+k. Lanes that fall past the end of the window are dropped. Read data is registered and appears one cycle after the request.

Top module: `fbc_regs_irq`

## Requirements
- R1: After a synchronous active-low reset, the interrupt output is low, the control byte and every general byte read 0x00, and the status byte reads 0x61.
- R2: The control byte at offset 0x10 stores all eight bits written and reads them back. Bit 7 is the interrupt enable.
- R3: A read of the status byte at offset 0x11 returns 0x61 ORed with the pending flag in bit 7. Data written to the status byte never changes bits 6..0.
- R4: An end-of-frame pulse in a cycle where control bit 7 is 1 sets the pending flag, and the interrupt output is high from the next cycle.
- R5: While the interrupt output is low, it stays low unless an end-of-frame pulse arrives with control bit 7 set.
- R6: A write covering offset 0x11, whatever the data, clears the pending flag, and the interrupt output is low from the next cycle.
- R7: If an end-of-frame pulse with control bit 7 set and a status write occur in the same cycle, the pending flag ends up set.
- R8: Offsets 0x12 to 0x1F each store one byte written and return it on read.
- R9: Offsets 0x00 to 0x0F read as zero, and writes to them change no register.
- R10: An access of length L (bus_len_i = L-1, 1 to 4 bytes) touches offsets addr..addr+L-1 on lanes 0..L-1. Read lanes beyond L, or past offset 0x1F, return zero. Write lanes past 0x1F are ignored.
- R11: bus_rvalid_o is high in exactly the cycle after a cycle with bus_rd_i high, and bus_rdata_o then holds the data for that request.
- R12: The interrupt output equals the pending flag. It stays high until a status write clears it, even if the enable bit is cleared meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| eof_pulse_i | input | 1 | One-cycle end-of-frame strobe from scanout |
| bus_wr_i | input | 1 | Write request this cycle |
| bus_rd_i | input | 1 | Read request this cycle |
| bus_addr_i | input | 5 | Byte offset of the first byte accessed |
| bus_len_i | input | 2 | Access length in bytes minus one |
| bus_wdata_i | input | 32 | Write data, lane k carries byte addr+k |
| bus_rdata_o | output | 32 | Registered read data, lane k holds byte addr+k |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| irq_o | output | 1 | Level frame interrupt |

## Verification
Suppose the pending flag takes a wrong value, for example because it was set while interrupts were disabled or an acknowledge was missed. irq_o shows the error on the very next cycle, and the next status read shows it in bit 7. A corrupted control or general byte, or a lane steered to the wrong offset, only becomes visible when that offset is read back. The bench therefore mixes writes and reads of overlapping multi-byte spans at every offset, so that such a fault shows within a few accesses. A wrong enable bit shows up one cycle after the next end-of-frame pulse, as a missing or spurious interrupt.

// File: rtl/fbc_pkg.sv
// Shared constants and helpers for the framebuffer control register block.
// Assumes a byte-addressed window split into a lower half owned elsewhere
// and an upper half of byte registers owned here.
package fbc_pkg;

    localparam int unsigned FBC_ADDR_W    = 5;
    localparam int unsigned FBC_BUS_BYTES = 4;

    // Register indices inside the upper half (offset minus half-window base)
    localparam int unsigned CTRL_IDX   = 0;
    localparam int unsigned STAT_IDX   = 1;
    localparam int unsigned STORE_BASE = 2;

    // Bit positions whose meaning the interrupt logic depends on
    localparam int unsigned IRQ_EN_BIT = 7;
    localparam int unsigned PEND_BIT   = 7;

    // Constant identification bits merged into every status read
    localparam logic [7:0] STAT_FIXED = 8'h61;

    typedef logic [7:0] fbc_byte_t;

    // Status byte as seen by a reader
    function automatic fbc_byte_t status_image(input logic pend);
        return STAT_FIXED | (fbc_byte_t'(pend) << PEND_BIT);
    endfunction

endpackage

// File: rtl/fbc_lane_map.sv
// Maps the byte lanes of a 1..BUS_BYTES access onto the upper-half registers.
// Assumes: lane k addresses offset addr+k; lanes past the window end or in
// the lower half select nothing, so lower-half accesses are inert.
module fbc_lane_map #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned BUS_BYTES = 4,
    localparam int unsigned LEN_W    = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
    localparam int unsigned IDX_W    = ADDR_W - 1,
    localparam int unsigned NREG     = 2 ** IDX_W
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [LEN_W-1:0]               len_i,
    input  logic                           wr_i,
    input  logic [8*BUS_BYTES-1:0]         wdata_i,
    output logic [BUS_BYTES-1:0]           lane_hit_o,
    output logic [BUS_BYTES-1:0][IDX_W-1:0] lane_idx_o,
    output logic [NREG-1:0]                reg_we_o,
    output logic [NREG-1:0][7:0]           reg_wbyte_o
);

    // Per-lane target offset, range and half checks
    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
        logic [ADDR_W:0] target;
        assign target        = {1'b0, addr_i} + (ADDR_W+1)'(k);
        assign lane_hit_o[k] = (int'(len_i) >= k) && !target[ADDR_W] && target[ADDR_W-1];
        assign lane_idx_o[k] = target[IDX_W-1:0];
    end

    // Steer each active write lane to its register strobe and data byte
    always_comb begin
        reg_we_o    = '0;
        reg_wbyte_o = '0;
        for (int k = 0; k < BUS_BYTES; k++) begin
            if (wr_i && lane_hit_o[k]) begin
                reg_we_o[lane_idx_o[k]]    = 1'b1;
                reg_wbyte_o[lane_idx_o[k]] = wdata_i[8*k +: 8];
            end
        end
    end

endmodule

// File: rtl/fbc_irq_ctrl.sv
// Control byte and sticky pending flag of the frame interrupt.
// Assumes: the end-of-frame strobe is one cycle wide and synchronous; a set
// from an enabled frame end takes priority over a same-cycle acknowledge.
module fbc_irq_ctrl
    import fbc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ctrl_we_i,
    input  logic [7:0] ctrl_wbyte_i,
    input  logic       ack_i,
    input  logic       eof_i,
    output logic [7:0] ctrl_o,
    output logic       pend_o
);

    logic [7:0] ctrl_q;
    logic       pend_q;

    // Control byte storage
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        ctrl_q <= '0;
        else if (ctrl_we_i) ctrl_q <= ctrl_wbyte_i;
    end

    // Pending flag: enabled frame end sets, status write clears, set wins
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                          pend_q <= 1'b0;
        else if (eof_i && ctrl_q[IRQ_EN_BIT]) pend_q <= 1'b1;
        else if (ack_i)                       pend_q <= 1'b0;
    end

    assign ctrl_o = ctrl_q;
    assign pend_o = pend_q;

endmodule

// File: rtl/fbc_store_bank.sv
// Plain read/write byte registers for cursor and timing values.
// Assumes one write strobe and data byte per register, all reset to zero.
module fbc_store_bank #(
    parameter int unsigned NSTORE = 14
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NSTORE-1:0]      we_i,
    input  logic [NSTORE-1:0][7:0] wbyte_i,
    output logic [NSTORE-1:0][7:0] store_o
);

    for (genvar j = 0; j < NSTORE; j++) begin : g_byte
        logic [7:0] byte_q;
        // One storage byte, loaded on its own strobe
        always_ff @(posedge clk_i) begin
            if (!rst_ni)    byte_q <= '0;
            else if (we_i[j]) byte_q <= wbyte_i[j];
        end
        assign store_o[j] = byte_q;
    end

endmodule

// File: rtl/fbc_read_port.sv
// Gathers the read image onto the bus lanes and registers the result.
// Assumes lanes without a hit (lower half, past the end, beyond length) are zero.
module fbc_read_port #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned BUS_BYTES = 4,
    localparam int unsigned IDX_W    = ADDR_W - 1,
    localparam int unsigned NREG     = 2 ** IDX_W
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            rd_i,
    input  logic [BUS_BYTES-1:0]            lane_hit_i,
    input  logic [BUS_BYTES-1:0][IDX_W-1:0] lane_idx_i,
    input  logic [NREG-1:0][7:0]            image_i,
    output logic [8*BUS_BYTES-1:0]          rdata_o,
    output logic                            rvalid_o
);

    logic [8*BUS_BYTES-1:0] gather;

    // Select one image byte per active lane
    always_comb begin
        gather = '0;
        for (int k = 0; k < BUS_BYTES; k++) begin
            if (lane_hit_i[k]) gather[8*k +: 8] = image_i[lane_idx_i[k]];
        end
    end

    // Register read data and its valid flag
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_i;
            if (rd_i) rdata_o <= gather;
        end
    end

endmodule

// File: rtl/fbc_regs_irq.sv
// Top of the framebuffer control register and interrupt unit.
// Assumes read and write are not requested in the same cycle by the bus;
// if they are, the read returns the state before the write.
module fbc_regs_irq
    import fbc_pkg::*;
#(
    parameter int unsigned ADDR_W    = FBC_ADDR_W,
    parameter int unsigned BUS_BYTES = FBC_BUS_BYTES,
    localparam int unsigned LEN_W    = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
    localparam int unsigned IDX_W    = ADDR_W - 1,
    localparam int unsigned NREG     = 2 ** IDX_W,
    localparam int unsigned NSTORE   = NREG - STORE_BASE
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   eof_pulse_i,
    input  logic                   bus_wr_i,
    input  logic                   bus_rd_i,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [LEN_W-1:0]       bus_len_i,
    input  logic [8*BUS_BYTES-1:0] bus_wdata_i,
    output logic [8*BUS_BYTES-1:0] bus_rdata_o,
    output logic                   bus_rvalid_o,
    output logic                   irq_o
);

    logic [BUS_BYTES-1:0]            lane_hit;
    logic [BUS_BYTES-1:0][IDX_W-1:0] lane_idx;
    logic [NREG-1:0]                 reg_we;
    logic [NREG-1:0][7:0]            reg_wbyte;
    logic [7:0]                      stat_wbyte_unused;
    logic [7:0]                      ctrl_q;
    logic                            pend_q;
    logic                            irq_en;
    logic [NSTORE-1:0][7:0]          store_q;
    logic [NREG-1:0][7:0]            image;

    fbc_lane_map #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) lane_i (
        .addr_i      (bus_addr_i),
        .len_i       (bus_len_i),
        .wr_i        (bus_wr_i),
        .wdata_i     (bus_wdata_i),
        .lane_hit_o  (lane_hit),
        .lane_idx_o  (lane_idx),
        .reg_we_o    (reg_we),
        .reg_wbyte_o (reg_wbyte)
    );

    // Status write data is discarded: the write itself is the acknowledge
    assign stat_wbyte_unused = reg_wbyte[STAT_IDX];

    fbc_irq_ctrl irq_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ctrl_we_i    (reg_we[CTRL_IDX]),
        .ctrl_wbyte_i (reg_wbyte[CTRL_IDX]),
        .ack_i        (reg_we[STAT_IDX]),
        .eof_i        (eof_pulse_i),
        .ctrl_o       (ctrl_q),
        .pend_o       (pend_q)
    );

    assign irq_en = ctrl_q[IRQ_EN_BIT];

    fbc_store_bank #(.NSTORE(NSTORE)) store_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we[NREG-1:STORE_BASE]),
        .wbyte_i (reg_wbyte[NREG-1:STORE_BASE]),
        .store_o (store_q)
    );

    // Read image of the upper half
    always_comb begin
        image                        = '0;
        image[CTRL_IDX]              = ctrl_q;
        image[STAT_IDX]              = status_image(pend_q);
        image[NREG-1:STORE_BASE]     = store_q;
    end

    fbc_read_port #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) rd_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_i       (bus_rd_i),
        .lane_hit_i (lane_hit),
        .lane_idx_i (lane_idx),
        .image_i    (image),
        .rdata_o    (bus_rdata_o),
        .rvalid_o   (bus_rvalid_o)
    );

    // The interrupt line is the registered pending flag
    assign irq_o = pend_q;

endmodule

// File: rtl/fbc_regs_irq_chk.sv
// Temporal checks of the interrupt and read behaviour, bound to the top.
// Assumes default window geometry for the status offset computation.
module fbc_regs_irq_chk #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned LEN_W  = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              eof_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [LEN_W-1:0]  len_i,
    input logic              irq_i,
    input logic              rvalid_i,
    input logic [7:0]        rdata_lo_i,
    input logic              irq_en_i
);

    localparam int unsigned STAT_OFF = 2 ** (ADDR_W - 1) + 1;

    logic [ADDR_W:0] span_lo;
    logic [ADDR_W:0] span_hi;
    logic            stat_hit;
    logic            set_ev;

    // Independent view of "this write covers the status byte"
    assign span_lo  = {1'b0, addr_i};
    assign span_hi  = span_lo + (ADDR_W+1)'(len_i);
    assign stat_hit = wr_i && (span_lo <= (ADDR_W+1)'(STAT_OFF))
                           && (span_hi >= (ADDR_W+1)'(STAT_OFF));
    assign set_ev   = eof_i && irq_en_i;

    // R4 R7
    irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_ev |=> irq_i);

    // R5
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_i && !set_ev) |=> !irq_i);

    // R6
    irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_hit && !set_ev) |=> !irq_i);

    // R12
    irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i && !stat_hit) |=> irq_i);

    // R11
    rvalid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> rvalid_i);

    // R11
    rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> !rvalid_i);

    // R9
    low_half_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !addr_i[ADDR_W-1] && len_i == '0) |=> (rdata_lo_i == 8'h00));

    // R3
    status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !wr_i && addr_i == ADDR_W'(STAT_OFF))
            |=> (rdata_lo_i == {$past(irq_i), 7'h61}));

endmodule

bind fbc_regs_irq fbc_regs_irq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eof_i      (eof_pulse_i),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .len_i      (bus_len_i),
    .irq_i      (irq_o),
    .rvalid_i   (bus_rvalid_o),
    .rdata_lo_i (bus_rdata_o[7:0]),
    .irq_en_i   (irq_en)
);

// File: tb/fbc_regs_irq_tb_top.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared against a behavioural model of the register window.
module fbc_regs_irq_tb_top;

    logic        clk;
    logic        rst_n;
    logic        eof;
    logic        wr;
    logic        rd;
    logic [4:0]  addr;
    logic [1:0]  len;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rvalid;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_reg [16];
    bit         m_pend;

    fbc_regs_irq dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .eof_pulse_i  (eof),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_addr_i   (addr),
        .bus_len_i    (len),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .irq_o        (irq)
    );

    // 125 MHz clock
    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [7:0] exp_byte(int off);
        if (off < 16 || off > 31) return 8'h00;
        if (off == 17) return 8'h61 | (m_pend ? 8'h80 : 8'h00);
        return m_reg[off - 16];
    endfunction

    function automatic logic [31:0] exp_rdata(int a, int l);
        logic [31:0] v = '0;
        for (int k = 0; k < 4; k++)
            if (k <= l) v[8*k +: 8] = exp_byte(a + k);
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, update model at posedge, check at next negedge
    task automatic step(bit w, bit r, int a, int l, logic [31:0] d, bit e, string tag);
        logic [31:0] exp;
        bit en_old;
        bit hit;
        wr = w; rd = r; addr = 5'(a); len = 2'(l); wdata = d; eof = e;
        exp    = exp_rdata(a, l);
        en_old = m_reg[0][7];
        hit    = 0;
        @(posedge clk);
        if (w) begin
            for (int k = 0; k <= l; k++) begin
                if (a + k >= 16 && a + k <= 31) begin
                    if (a + k == 17) hit = 1;
                    else m_reg[a + k - 16] = d[8*k +: 8];
                end
            end
        end
        if (e && en_old) m_pend = 1;
        else if (hit)    m_pend = 0;
        @(negedge clk);
        check(irq == m_pend, {tag, " irq"}, 32'(irq), 32'(m_pend));
        if (r) check(rvalid && rdata == exp, {tag, " rdata"}, rdata, exp);
        else   check(!rvalid, {tag, " R11 idle"}, 32'(rvalid), 32'h0);
        wr = 0; rd = 0; eof = 0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        m_pend = 0;
        rst_n = 0; wr = 0; rd = 0; eof = 0; addr = '0; len = '0; wdata = '0;
        seed_dummy = $urandom(32'h5EED_0F1C);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        step(0, 1, 16, 0, 0, 0, "R1 ctrl");
        step(0, 1, 17, 0, 0, 0, "R1 status");
        step(0, 1, 18, 3, 0, 0, "R1 store");
        step(0, 1, 28, 3, 0, 0, "R1 store hi");
        // R2 control read/write
        step(1, 0, 16, 0, 32'h0000_00A5, 0, "R2 wr");
        step(0, 1, 16, 0, 0, 0, "R2 rd");
        // R5 frame end with enable clear
        step(1, 0, 16, 0, 32'h0000_0000, 0, "R5 dis");
        step(0, 0, 0, 0, 0, 1, "R5 eof");
        step(0, 1, 17, 0, 0, 0, "R5 status");
        // R4 enabled frame end
        step(1, 0, 16, 0, 32'h0000_0080, 0, "R4 en");
        step(0, 0, 0, 0, 0, 1, "R4 eof");
        step(0, 1, 17, 0, 0, 0, "R4 status");
        // R12 sticky after disable
        step(1, 0, 16, 0, 32'h0000_0000, 0, "R12 dis");
        step(0, 1, 16, 1, 0, 0, "R12 rd");
        // R6 acknowledge with zero data, R3 data ignored
        step(1, 0, 17, 0, 32'h0000_0000, 0, "R6 ack");
        step(0, 1, 17, 0, 0, 0, "R6 status");
        step(1, 0, 17, 0, 32'h0000_001E, 0, "R3 wr");
        step(0, 1, 17, 0, 0, 0, "R3 status");
        // R7 frame end and acknowledge together
        step(1, 0, 16, 0, 32'h0000_0080, 0, "R7 en");
        step(1, 0, 17, 0, 32'h0000_00FF, 1, "R7 race");
        step(0, 1, 16, 1, 0, 0, "R7 rd");
        // R8 storage bytes
        step(1, 0, 31, 0, 32'h0000_005A, 0, "R8 wr");
        step(0, 1, 31, 0, 0, 0, "R8 rd");
        step(1, 0, 18, 0, 32'h0000_00C3, 0, "R8 wr lo");
        step(0, 1, 18, 0, 0, 0, "R8 rd lo");
        // R9 lower half inert
        step(1, 0, 4, 3, 32'hDEAD_BEEF, 0, "R9 wr");
        step(0, 1, 0, 3, 0, 0, "R9 rd");
        step(0, 1, 12, 3, 0, 0, "R9 rd hi");
        step(1, 0, 14, 3, 32'h7711_2233, 0, "R9 span");
        step(0, 1, 14, 3, 0, 0, "R9 span rd");
        // R10 multi-byte lanes and window end
        step(1, 0, 18, 3, 32'h4433_2211, 0, "R10 wr4");
        step(0, 1, 18, 3, 0, 0, "R10 rd4");
        step(0, 1, 19, 1, 0, 0, "R10 rd2");
        step(1, 0, 30, 3, 32'h9988_7766, 0, "R10 wr end");
        step(0, 1, 29, 3, 0, 0, "R10 rd end");
        step(0, 1, 31, 3, 0, 0, "R10 rd last");
        step(0, 1, 20, 2, 0, 0, "R10 rd3");

        // Seeded random traffic, all requirements via the model
        for (int i = 0; i < 1500; i++) begin
            int op = int'($urandom_range(0, 9));
            int a  = int'($urandom_range(0, 31));
            int l  = int'($urandom_range(0, 3));
            bit e  = ($urandom_range(0, 5) == 0);
            logic [31:0] d = $urandom;
            if (op < 3 && a < 16) a = a + 16;
            if (op == 9) a = 16;
            if (op < 4 || op == 9) step(1, 0, a, l, d, e, "R10 rnd wr");
            else if (op < 8)       step(0, 1, a, l, 0, e, "R10 rnd rd");
            else                   step(0, 0, a, l, 0, e, "R4 rnd idle");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule